// File: doc/BRIEF.md
# Serial Sensor Clock Burst Generator

This block produces the clock bursts a serial encoder-interface master drives towards its sensors. A system clock is divided by a ratio taken from an 8-bit frequency code. The low five bits pick a prescaler from one of two ranges. The first is a fine range of even divisors. The second is a coarse range in steps of twenty. One code value in between is forbidden. In register-access mode, the top three bits add a power-of-two post-divider.

The generated clock rests high between bursts. A burst starts on a start request and ends at the first rising edge after a stop request. The clock fans out to four channel lines. A channel-select vector splits the lines into selected and unselected groups. Each group can replace the generated clock with a static level of its own. A one-cycle strobe marks every rising edge of the generated clock. The frequency code and mode are captured when a burst starts, so the code can be reprogrammed at any time without disturbing a running burst.

Top module: `enc_clk_master`

## Requirements
- R1: For code bits 4:0 in 0x00..0x0F in normal mode (reg_mode=0), the clock period is 2×(c+1) system cycles, with low and high phases of c+1 cycles each.
- R2: For code bits 4:0 in 0x11..0x1F in normal mode, the period is 20×(c−0x0F) cycles, with each phase lasting half of that.
- R3: When code bits 4:0 equal 0x10, code_err is 1 whatever bits 7:5 hold, and a start request produces no clock: every line stays high and rise_stb stays 0. For any other value of bits 4:0, code_err is 0.
- R4: With reg_mode=1, each phase is the sensor phase of R1/R2 multiplied by 2^(k+1), where k is code bits 7:5. With reg_mode=0, bits 7:5 have no effect.
- R5: While idle the generated clock is high. On the cycle after an accepted start request the clock falls. The low and high phases are then equal in length.
- R6: The code and the mode are captured when a start request is accepted. Changing them during a burst leaves the phase length unchanged.
- R7: A stop request ends the burst at the next rising edge. After that edge the clock stays high until the next start request.
- R8: rise_stb is high for exactly the one cycle in which the generated clock has just gone from low to high, and is low at every other time.
- R9: A channel with ch_sel[i]=1 outputs sel_level when sel_force=1, and outputs the generated clock otherwise.
- R10: A channel with ch_sel[i]=0 outputs uns_level when uns_force=1, and outputs the generated clock otherwise.
- R11: A start request that arrives while a burst is running is ignored.
- R12: During reset every channel line is high and rise_stb is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_code | input | 8 | Prescaler code in bits 4:0, register post-divider exponent in bits 7:5 |
| reg_mode | input | 1 | 1 selects the register-access ratio set |
| ch_sel | input | 4 | 1 marks a channel as selected |
| sel_force | input | 1 | Selected channels output a static level |
| sel_level | input | 1 | Static level for selected channels |
| uns_force | input | 1 | Unselected channels output a static level |
| uns_level | input | 1 | Static level for unselected channels |
| burst_start | input | 1 | Start request, sampled while idle |
| burst_stop | input | 1 | Stop request, acted on at the next rising edge |
| ch_clk | output | 4 | Channel clock lines |
| rise_stb | output | 1 | One-cycle strobe on each rising edge of the generated clock |
| code_err | output | 1 | Forbidden prescaler code is programmed |

## Verification
The assertions assume that start and stop arrive as synchronous single-cycle requests. They also assume that the lines are observed only through the selection and override inputs, which may change on any cycle. The stimulus therefore changes every input just after a falling clock edge. It holds start and stop high for one cycle only. It keeps every programmed divisor within the counter width. The longest case is a register-mode exponent of 7 on small prescaler codes, which keeps each run short. Each phase length is counted at the ports against a value computed arithmetically.

// File: rtl/enc_clk_pkg.sv
package enc_clk_pkg;
   localparam int PRE_W          = 5;
   localparam int POST_W         = 3;
   localparam int CODE_W         = PRE_W + POST_W;
   localparam logic [PRE_W-1:0] FORBID_CODE = 5'h10;
   localparam int FINE_LAST      = 15;
   localparam int COARSE_STEP    = 10;
   localparam int MAX_SENS_HALF  = (2**PRE_W - 1 - FINE_LAST) * COARSE_STEP;
   localparam int MAX_POST       = 2**(2**POST_W);
   localparam int MAX_HALF       = MAX_SENS_HALF * MAX_POST;
   localparam int HALF_W         = $clog2(MAX_HALF + 1);

   typedef struct packed {
      logic sel_force;
      logic sel_level;
      logic uns_force;
      logic uns_level;
   } ovr_t;
endpackage

// File: rtl/enc_clk_div_decode.sv
module enc_clk_div_decode
   import enc_clk_pkg::*;
#(
   parameter int HW     = HALF_W,
   parameter bit REG_EN = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   input  logic              reg_mode,
   output logic [HW-1:0]     half,
   output logic              illegal
);
   localparam int SH_W = POST_W + 1;

   logic [PRE_W-1:0] pre;
   logic [HW-1:0]    sens_half;

   assign pre     = code[PRE_W-1:0];
   assign illegal = (pre == FORBID_CODE);

   always_comb begin
      if (pre <= PRE_W'(FINE_LAST))
         sens_half = HW'(pre) + HW'(1);
      else
         sens_half = HW'(pre - PRE_W'(FINE_LAST)) * HW'(COARSE_STEP);
   end

   generate
      if (REG_EN) begin : g_post
         logic [SH_W-1:0] shamt;
         assign shamt = {1'b0, code[CODE_W-1:PRE_W]} + SH_W'(1);
         assign half  = reg_mode ? (sens_half << shamt) : sens_half;
      end else begin : g_nopost
         logic unused_rm;
         assign unused_rm = reg_mode ^ (^code[CODE_W-1:PRE_W]);
         assign half      = sens_half;
      end
   endgenerate
endmodule

// File: rtl/enc_clk_burst.sv
module enc_clk_burst #(
   parameter int HW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          stop,
   input  logic [HW-1:0] half,
   input  logic          illegal,
   output logic          gen_clk,
   output logic          rise_stb,
   output logic          busy
);
   logic [HW-1:0] half_q;
   logic [HW-1:0] cnt;
   logic          stop_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         gen_clk   <= 1'b1;
         rise_stb  <= 1'b0;
         half_q    <= '0;
         cnt       <= '0;
         stop_pend <= 1'b0;
      end else begin
         rise_stb <= 1'b0;
         if (!busy) begin
            stop_pend <= 1'b0;
            gen_clk   <= 1'b1;
            if (start && !illegal) begin
               busy    <= 1'b1;
               gen_clk <= 1'b0;
               half_q  <= half;
               cnt     <= half - HW'(1);
            end
         end else begin
            if (stop)
               stop_pend <= 1'b1;
            if (cnt == '0) begin
               cnt     <= half_q - HW'(1);
               gen_clk <= ~gen_clk;
               if (!gen_clk) begin
                  rise_stb <= 1'b1;
                  if (stop_pend || stop)
                     busy <= 1'b0;
               end
            end else begin
               cnt <= cnt - HW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/enc_clk_route.sv
module enc_clk_route
   import enc_clk_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic           gen_clk,
   input  logic [NCH-1:0] ch_sel,
   input  ovr_t           ovr,
   output logic [NCH-1:0] ch_clk
);
   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         always_comb begin
            if (ch_sel[i])
               ch_clk[i] = ovr.sel_force ? ovr.sel_level : gen_clk;
            else
               ch_clk[i] = ovr.uns_force ? ovr.uns_level : gen_clk;
         end
      end
   endgenerate
endmodule

// File: rtl/enc_clk_master.sv
module enc_clk_master
   import enc_clk_pkg::*;
#(
   parameter int NCH    = 4,
   parameter bit REG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] freq_code,
   input  logic              reg_mode,
   input  logic [NCH-1:0]    ch_sel,
   input  logic              sel_force,
   input  logic              sel_level,
   input  logic              uns_force,
   input  logic              uns_level,
   input  logic              burst_start,
   input  logic              burst_stop,
   output logic [NCH-1:0]    ch_clk,
   output logic              rise_stb,
   output logic              code_err
);
   localparam int HW = REG_EN ? HALF_W : $clog2(MAX_SENS_HALF + 1);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("enc_clk_master: NCH must be at least 1");
      end
      if (HW < 8) begin : g_bad_hw
         $error("enc_clk_master: counter too narrow");
      end
   endgenerate

   logic [HW-1:0] half_w;
   logic          gen_w;
   logic          busy_w;
   ovr_t          ovr_w;

   assign ovr_w = '{sel_force: sel_force, sel_level: sel_level,
                    uns_force: uns_force, uns_level: uns_level};

   enc_clk_div_decode #(.HW(HW), .REG_EN(REG_EN)) u_dec (
      .code    (freq_code),
      .reg_mode(reg_mode),
      .half    (half_w),
      .illegal (code_err)
   );

   enc_clk_burst #(.HW(HW)) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (burst_start),
      .stop    (burst_stop),
      .half    (half_w),
      .illegal (code_err),
      .gen_clk (gen_w),
      .rise_stb(rise_stb),
      .busy    (busy_w)
   );

   enc_clk_route #(.NCH(NCH)) u_route (
      .gen_clk(gen_w),
      .ch_sel (ch_sel),
      .ovr    (ovr_w),
      .ch_clk (ch_clk)
   );
endmodule

// File: rtl/enc_clk_master_chk.sv
module enc_clk_master_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           gen_clk,
   input logic           busy,
   input logic           rise_stb,
   input logic           code_err,
   input logic           burst_start,
   input logic [NCH-1:0] ch_sel,
   input logic [NCH-1:0] ch_clk,
   input logic           sel_force,
   input logic           sel_level,
   input logic           uns_force,
   input logic           uns_level
);
   AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && burst_start && code_err) |=> !busy); // R3
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> gen_clk); // R5
   AST_START_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && burst_start && !code_err) |=> (busy && !gen_clk)); // R5
   AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (gen_clk && !$past(gen_clk))); // R8
   AST_RISE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gen_clk) |-> rise_stb); // R8

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         AST_SEL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[i] && sel_force) |-> (ch_clk[i] == sel_level)); // R9
         AST_SEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[i] && !sel_force) |-> (ch_clk[i] == gen_clk)); // R9
         AST_UNS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_sel[i] && uns_force) |-> (ch_clk[i] == uns_level)); // R10
         AST_UNS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_sel[i] && !uns_force) |-> (ch_clk[i] == gen_clk)); // R10
      end
   endgenerate
endmodule

bind enc_clk_master enc_clk_master_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gen_clk    (gen_w),
   .busy       (busy_w),
   .rise_stb   (rise_stb),
   .code_err   (code_err),
   .burst_start(burst_start),
   .ch_sel     (ch_sel),
   .ch_clk     (ch_clk),
   .sel_force  (sel_force),
   .sel_level  (sel_level),
   .uns_force  (uns_force),
   .uns_level  (uns_level)
);

// File: tb/sim_enc_clk_master.sv
`timescale 1ns/1ps
module sim_enc_clk_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] freq_code = 8'h00;
   logic       reg_mode = 1'b0;
   logic [3:0] ch_sel = 4'b0001;
   logic       sel_force = 1'b0, sel_level = 1'b0;
   logic       uns_force = 1'b0, uns_level = 1'b0;
   logic       burst_start = 1'b0, burst_stop = 1'b0;
   logic [3:0] ch_clk;
   logic       rise_stb, code_err;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   enc_clk_master u0 (
      .clk(clk), .rst_n(rst_n), .freq_code(freq_code), .reg_mode(reg_mode),
      .ch_sel(ch_sel), .sel_force(sel_force), .sel_level(sel_level),
      .uns_force(uns_force), .uns_level(uns_level),
      .burst_start(burst_start), .burst_stop(burst_stop),
      .ch_clk(ch_clk), .rise_stb(rise_stb), .code_err(code_err)
   );

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int exp_half(input logic [7:0] code, input bit rm);
      int lo = int'(code[4:0]);
      int h  = (lo <= 15) ? lo + 1 : (lo - 15) * 10;
      if (rm) h = h * (2 ** (int'(code[7:5]) + 1));
      return h;
   endfunction

   // Runs one burst on channel 0, measures both phases, then stops it.
   task automatic measure(input logic [7:0] code, input bit rm, input string req,
                          input bit disturb);
      int h = exp_half(code, rm);
      int n, m, k;
      freq_code = code; reg_mode = rm; ch_sel = 4'b0001;
      sel_force = 0; uns_force = 0;
      burst_start = 1; tick(); burst_start = 0;
      chk(ch_clk[0] == 1'b0, "R5 falls after start", ch_clk[0], 0);
      if (disturb) begin
         freq_code = code ^ 8'h07; reg_mode = ~rm;
         burst_start = 1; tick(); burst_start = 0;   // R6 R11
         n = 1;
      end else n = 0;
      while (ch_clk[0] == 1'b0 && n < 100000) begin n++; tick(); end
      chk(n == h, req, n, h);
      chk(rise_stb == 1'b1, "R8 strobe on rise", rise_stb, 1);
      m = 0;
      while (ch_clk[0] == 1'b1 && m < 100000) begin
         m++;
         if (m == 2) chk(rise_stb == 1'b0, "R8 strobe one cycle", rise_stb, 0);
         tick();
      end
      chk(m == h, "R5 high phase equals low phase", m, h);
      burst_stop = 1; tick(); burst_stop = 0;
      k = 0;
      while (ch_clk[0] == 1'b0 && k < 100000) begin k++; tick(); end
      for (int i = 0; i < 2*h + 3; i++) begin
         if (ch_clk[0] != 1'b1 || (i > 0 && rise_stb)) begin
            chk(1'b0, "R7 stays high after stop", ch_clk[0], 1);
            break;
         end
         tick();
      end
      chk(ch_clk[0] == 1'b1, "R7 idle high", ch_clk[0], 1);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      tick(); tick();
      chk(ch_clk == 4'hF, "R12 lines high in reset", ch_clk, 15);
      chk(rise_stb == 1'b0, "R12 no strobe in reset", rise_stb, 0);
      rst_n = 1; tick(); tick();

      // R1 R2 R4: normal mode, every legal code, random upper bits ignored
      for (int c = 0; c < 32; c++) begin
         if (c == 16) continue;
         measure({3'(c % 8), 5'(c)}, 1'b0, c < 16 ? "R1 fine phase" : "R2 coarse phase R4 ignores k", 1'b0);
      end
      // R4: register mode, every legal code with k=0
      for (int c = 0; c < 32; c++) begin
         if (c == 16) continue;
         measure({3'd0, 5'(c)}, 1'b1, "R4 register phase k=0", 1'b0);
      end
      // R4: exponent sweep
      for (int c = 0; c < 4; c++)
         for (int k = 0; k < 8; k++)
            measure({3'(k), 5'(c)}, 1'b1, "R4 register phase sweep", 1'b0);
      measure(8'h11, 1'b1, "R4 coarse register", 1'b0);
      // R6 R11: changing code/mode and re-starting mid-burst
      measure(8'h05, 1'b0, "R6 R11 config held during burst", 1'b1);
      measure(8'h22, 1'b1, "R6 R11 config held (reg)", 1'b1);

      // R3 forbidden code
      freq_code = 8'h10; reg_mode = 0; tick();
      chk(code_err == 1'b1, "R3 error flag", code_err, 1);
      freq_code = 8'hF0; reg_mode = 1; tick();
      chk(code_err == 1'b1, "R3 error flag upper bits", code_err, 1);
      burst_start = 1; tick(); burst_start = 0;
      for (int i = 0; i < 40; i++) begin
         if (ch_clk != 4'hF || rise_stb) begin
            chk(1'b0, "R3 no clock on forbidden code", ch_clk, 15);
            break;
         end
         tick();
      end
      chk(ch_clk == 4'hF, "R3 lines idle", ch_clk, 15);
      freq_code = 8'h0F; tick();
      chk(code_err == 1'b0, "R3 legal code clears error", code_err, 0);
      freq_code = 8'h11; tick();
      chk(code_err == 1'b0, "R3 coarse legal code", code_err, 0);

      // R9 R10 overrides, in the low phase of a long period
      freq_code = 8'h1F; reg_mode = 0;
      burst_start = 1; tick(); burst_start = 0; tick();
      for (int p = 0; p < 2; p++) begin
         ch_sel = (p == 0) ? 4'b0101 : 4'b1100;
         for (int v = 0; v < 16; v++) begin
            logic [3:0] ex;
            {sel_force, sel_level, uns_force, uns_level} = 4'(v);
            tick();
            for (int i = 0; i < 4; i++)
               ex[i] = ch_sel[i] ? (sel_force ? sel_level : 1'b0)
                                 : (uns_force ? uns_level : 1'b0);
            chk(ch_clk == ex, ch_sel[0] ? "R9 R10 override (sel 0101)" : "R9 R10 override (sel 1100)", ch_clk, ex);
         end
      end
      sel_force = 0; uns_force = 1; uns_level = 0; ch_sel = 4'b0011;
      burst_stop = 1; tick(); burst_stop = 0;
      while (ch_clk[0] == 1'b0) tick();
      tick();
      chk(ch_clk == 4'b0011, "R10 forced low while idle, R9 selected follow high", ch_clk, 3);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule